// File: doc/BRIEF.md
# Serial Identifier CRC Checker

This block takes in a 64-bit device identifier one bit per accepted cycle, lowest bit first. It builds the identifier word in a shift register. It runs an 8-bit CRC over the first 56 bits only. The final 8 bits hold the check byte. When the last bit arrives, the block compares that byte, taken as it is with no inversion, against its computed CRC. It then pulses a done flag and reports whether the two match.

A start strobe opens every frame. It clears the identifier, the bit counter, the CRC register and the match flag. If the strobe arrives in the middle of a frame, that frame is dropped and reception begins again from the first bit.

The controller has four states:
- `S_IDLE`: waits for a start.
- `S_BODY`: takes the 56 covered bits.
- `S_TAIL`: takes the 8 check bits.
- `S_DONE`: lasts one cycle and marks completion.

The transitions are:
- start from any state to `S_BODY` (called "open").
- 56th accepted bit from `S_BODY` to `S_TAIL` ("body_full").
- 64th accepted bit from `S_TAIL` to `S_DONE` ("frame_full").
- `S_DONE` to `S_IDLE` when no start is present ("retire").

Top module: `idcrc_checker`

## Requirements
- R1: While reset is held and after it is released, `id_o` is zero, `done_o` is low and `crc_ok_o` is low, and the block is idle.
- R2: Bits are taken least significant first: after a complete frame, `id_o[i]` equals the i-th accepted bit, counting from 0.
- R3: A bit is accepted only when `bit_valid_i` is high, `start_i` is low and a frame is open. Bits presented while idle, after completion or with `bit_valid_i` low leave `id_o` unchanged.
- R4: The CRC is the reflected form of x^8+x^5+x^4+1 (right shift, feedback mask 0x8C, input bit XORed with the register LSB). It starts at 0x00 and is updated by the first 56 accepted bits only.
- R5: `done_o` is high for exactly one cycle: the cycle after the clock edge that accepts the 64th bit.
- R6: `crc_ok_o` rises together with `done_o` when the computed CRC equals `id_o[63:56]` with no complement, and stays low otherwise. It holds its value until the next start.
- R7: A start strobe in any state, including mid-frame, clears `id_o`, `crc_ok_o`, the bit counter and the CRC. The next 64 accepted bits then form a new frame.
- R8: A bit presented in the same cycle as a start strobe is not accepted.
- R9: `crc_ok_o` is high exactly when a CRC run over all 64 received bits leaves a residue of 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start / abort strobe |
| bit_valid_i | input | 1 | Qualifies `bit_i` this cycle |
| bit_i | input | 1 | Serial identifier bit |
| id_o | output | 64 | Identifier assembled so far |
| done_o | output | 1 | One-cycle completion pulse |
| crc_ok_o | output | 1 | Check byte matched the computed CRC |

## Verification
A bit counter that is off by one moves the body/tail boundary. That shows up as a wrong `crc_ok_o` at the first frame's done pulse, and as a done pulse one cycle early or late. A CRC register that keeps running into the tail, or misses a bit, corrupts the match verdict at completion. Wrong shift direction or gating appears in `id_o` on the very next clock, because the bench compares the word against its own model every cycle. State left behind after an abort shows up in the frame that follows.

// File: rtl/idcrc_pkg.sv
package idcrc_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_BODY = 2'd1,
        S_TAIL = 2'd2,
        S_DONE = 2'd3
    } idcrc_state_e;
endpackage

// File: rtl/idcrc_lfsr.sv
module idcrc_lfsr #(
    parameter int          WIDTH = 8,
    parameter logic [WIDTH-1:0] MASK = 8'h8C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] crc_o
);
    logic [WIDTH-1:0] crc_q;
    logic [WIDTH-1:0] crc_d;
    logic             fb;

    // Reflected shift: feedback is input XOR current LSB
    always_comb begin
        fb    = crc_q[0] ^ bit_i;
        crc_d = (crc_q >> 1) ^ (fb ? MASK : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            crc_q <= '0;
        else if (clr_i)
            crc_q <= '0;
        else if (en_i)
            crc_q <= crc_d;
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/idcrc_shifter.sv
module idcrc_shifter #(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic         bit_i,
    output logic [N-1:0] word_o
);
    logic [N-1:0] word_q;

    // New bit enters at the top; after N shifts the first bit sits at bit 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            word_q <= '0;
        else if (clr_i)
            word_q <= '0;
        else if (en_i)
            word_q <= {bit_i, word_q[N-1:1]};
    end

    assign word_o = word_q;
endmodule

// File: rtl/idcrc_ctrl.sv
module idcrc_ctrl
    import idcrc_pkg::*;
#(
    parameter int ID_BITS  = 64,
    parameter int CRC_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic bit_valid_i,
    output logic clr_o,
    output logic shift_en_o,
    output logic crc_en_o,
    output logic last_o,
    output logic done_o
);
    localparam int DATA_BITS = ID_BITS - CRC_BITS;
    localparam int CW        = $clog2(ID_BITS);
    localparam logic [CW-1:0] BODY_LAST  = CW'(DATA_BITS - 1);
    localparam logic [CW-1:0] FRAME_LAST = CW'(ID_BITS - 1);

    idcrc_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          accept;

    assign accept = bit_valid_i && !start_i &&
                    ((state_q == S_BODY) || (state_q == S_TAIL));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start_i) state_d = S_BODY;
            S_BODY: begin
                if (start_i)                              state_d = S_BODY;
                else if (accept && cnt_q == BODY_LAST)    state_d = S_TAIL;
            end
            S_TAIL: begin
                if (start_i)                              state_d = S_BODY;
                else if (accept && cnt_q == FRAME_LAST)   state_d = S_DONE;
            end
            S_DONE: state_d = start_i ? S_BODY : S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start_i)
            cnt_q <= '0;
        else if (accept)
            cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        clr_o      = start_i;
        shift_en_o = accept;
        crc_en_o   = accept && (state_q == S_BODY);
        last_o     = accept && (state_q == S_TAIL) && (cnt_q == FRAME_LAST);
        done_o     = (state_q == S_DONE);
    end
endmodule

// File: rtl/idcrc_checker.sv
module idcrc_checker #(
    parameter int ID_BITS  = 64,
    parameter int CRC_BITS = 8,
    parameter logic [CRC_BITS-1:0] CRC_MASK = 8'h8C
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               bit_valid_i,
    input  logic               bit_i,
    output logic [ID_BITS-1:0] id_o,
    output logic               done_o,
    output logic               crc_ok_o
);
    logic                clr, shift_en, crc_en, last;
    logic [CRC_BITS-1:0] crc;
    logic                ok_q;

    idcrc_ctrl #(.ID_BITS(ID_BITS), .CRC_BITS(CRC_BITS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .bit_valid_i (bit_valid_i),
        .clr_o       (clr),
        .shift_en_o  (shift_en),
        .crc_en_o    (crc_en),
        .last_o      (last),
        .done_o      (done_o)
    );

    idcrc_shifter #(.N(ID_BITS)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .en_i   (shift_en),
        .bit_i  (bit_i),
        .word_o (id_o)
    );

    idcrc_lfsr #(.WIDTH(CRC_BITS), .MASK(CRC_MASK)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr),
        .en_i  (crc_en),
        .bit_i (bit_i),
        .crc_o (crc)
    );

    // Verdict latched on the edge taking the final bit; check byte is uninverted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ok_q <= 1'b0;
        else if (clr)
            ok_q <= 1'b0;
        else if (last)
            ok_q <= (crc == {bit_i, id_o[ID_BITS-1 -: CRC_BITS-1]});
    end

    assign crc_ok_o = ok_q;
endmodule

// File: rtl/idcrc_props.sv
module idcrc_props #(
    parameter int ID_BITS = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               bit_valid_i,
    input logic [ID_BITS-1:0] id_o,
    input logic               done_o,
    input logic               crc_ok_o
);
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_ok_rises_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_ok_o) |-> done_o);

    p_ok_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (done_o || $stable(crc_ok_o)));

    p_idle_bits_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_valid_i && !start_i) |=> $stable(id_o));

    p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (id_o == '0 && !crc_ok_o && !done_o));
endmodule

bind idcrc_checker idcrc_props #(.ID_BITS(ID_BITS)) u_props (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .bit_valid_i (bit_valid_i),
    .id_o        (id_o),
    .done_o      (done_o),
    .crc_ok_o    (crc_ok_o)
);

// File: tb/sim_idcrc_checker.sv
`timescale 1ns/1ps
module sim_idcrc_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        bit_valid_i = 1'b0;
    logic        bit_i = 1'b0;
    logic [63:0] id_o;
    logic        done_o;
    logic        crc_ok_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    idcrc_checker u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .bit_valid_i(bit_valid_i), .bit_i(bit_i),
        .id_o(id_o), .done_o(done_o), .crc_ok_o(crc_ok_o)
    );

    function automatic logic [7:0] crc_step(logic [7:0] c, logic b);
        logic fb = c[0] ^ b;
        c = c >> 1;
        if (fb) c = c ^ 8'h8C;
        return c;
    endfunction

    function automatic logic [7:0] crc_over(logic [63:0] v, int n);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < n; i++) c = crc_step(c, v[i]);
        return c;
    endfunction

    task automatic chk(bit cond, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    bit          m_open;
    int          m_cnt;
    logic [63:0] m_id;
    logic [7:0]  m_crc;
    bit          m_ok, m_done;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_open = 0; m_cnt = 0; m_id = '0; m_crc = 8'h00; m_ok = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (start_i) begin
                m_open = 1; m_cnt = 0; m_id = '0; m_crc = 8'h00; m_ok = 0;
            end else if (m_open && bit_valid_i) begin
                m_id = {bit_i, m_id[63:1]};
                if (m_cnt < 56) m_crc = crc_step(m_crc, bit_i);
                m_cnt++;
                if (m_cnt == 64) begin
                    m_open = 0; m_done = 1; m_ok = (m_crc == m_id[63:56]);
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(id_o == m_id, "R2 id_o per-cycle", id_o, m_id);
            chk(done_o == m_done, "R5 done_o per-cycle", 64'(done_o), 64'(m_done));
            chk(crc_ok_o == m_ok, "R6 crc_ok_o per-cycle", 64'(crc_ok_o), 64'(m_ok));
        end
    end

    task automatic drive(bit s, bit v, bit b);
        @(negedge clk);
        start_i = s; bit_valid_i = v; bit_i = b;
    endtask

    task automatic send_bits(logic [63:0] v, int n);
        for (int i = 0; i < n; i++) begin
            if ($urandom_range(0, 3) == 0) drive(0, 0, 1'($urandom));
            drive(0, 1, v[i]);
        end
    endtask

    task automatic run_frame(logic [63:0] v);
        bit exp_ok;
        send_bits(v, 64);
        drive(0, 0, 0);
        exp_ok = (crc_over(v, 56) == v[63:56]);
        chk(done_o == 1'b1, "R5 done after last bit", 64'(done_o), 64'd1);
        chk(id_o == v, "R2 id assembled LSB first", id_o, v);
        chk(crc_ok_o == exp_ok, "R4 CRC over 56 bits", 64'(crc_ok_o), 64'(exp_ok));
        chk(crc_ok_o == (crc_over(v, 64) == 8'h00), "R9 zero residue agrees",
            64'(crc_ok_o), 64'(crc_over(v, 64) == 8'h00));
        drive(0, 1, 1);
        chk(done_o == 1'b0, "R5 done one cycle", 64'(done_o), 64'd0);
        chk(crc_ok_o == exp_ok, "R6 verdict holds", 64'(crc_ok_o), 64'(exp_ok));
        drive(0, 1, 0);
        drive(0, 0, 0);
        chk(id_o == v, "R3 bits after completion ignored", id_o, v);
    endtask

    function automatic logic [63:0] make_id(bit good, int flip);
        logic [63:0] v;
        v[55:0]  = {$urandom, $urandom} & 56'hFF_FFFF_FFFF_FFFF;
        v[63:56] = crc_over(v, 56);
        if (!good) v[56 + (flip % 8)] = ~v[56 + (flip % 8)];
        return v;
    endfunction

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        repeat (3) @(negedge clk);
        chk(id_o == '0 && !done_o && !crc_ok_o, "R1 outputs in reset",
            {id_o[61:0], done_o, crc_ok_o}, 64'd0);
        rst_n = 1'b1;
        drive(0, 0, 0);
        chk(id_o == '0 && !done_o && !crc_ok_o, "R1 outputs after reset",
            {id_o[61:0], done_o, crc_ok_o}, 64'd0);
        // R3: bits before any start are ignored
        for (int i = 0; i < 5; i++) drive(0, 1, 1);
        drive(0, 0, 0);
        chk(id_o == '0, "R3 bits while idle ignored", id_o, 64'd0);

        for (int k = 0; k < 8; k++) begin
            drive(1, 0, 0);
            v = make_id(k % 2 == 0, k);
            run_frame(v);
        end

        // R7: abort mid-frame, then a full frame
        drive(1, 0, 0);
        v = make_id(1, 0);
        send_bits(~v, 30);
        drive(1, 0, 0);
        drive(0, 0, 0);
        chk(id_o == '0, "R7 abort clears id", id_o, 64'd0);
        run_frame(v);

        // R7: abort in tail phase
        drive(1, 0, 0);
        send_bits(v, 60);
        drive(1, 0, 0);
        v = make_id(1, 3);
        run_frame(v);

        // R8: bit alongside start is not accepted
        drive(1, 1, 1);
        v = make_id(1, 5);
        run_frame(v);
        drive(1, 1, 1);
        drive(0, 0, 0);
        chk(id_o == '0, "R8 bit with start ignored", id_o, 64'd0);

        // R6/R9: corrupted body bit
        v = make_id(1, 0);
        v[10] = ~v[10];
        run_frame(v);
        chk(crc_ok_o == 1'b0, "R6 corrupted body rejected", 64'(crc_ok_o), 64'd0);

        drive(0, 0, 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule